// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One counter channel of a six-mode programmable interval timer. It counts ticks of a clock-enable input, not raw clock edges. From that count it produces an output waveform chosen by a 3-bit mode code: an interrupt on terminal count, a gate-triggered one-shot, a rate generator, a square wave, and two single-cycle strobes. The same count also gives a 16-bit value that a surrounding register block can read back. Counting is binary only. The host bus, command decoding and readback latching are left to the logic that instantiates the channel.

A load strobe takes a new initial count and a new mode in the same cycle and restarts the cycle. The gate input does one of two things, depending on the mode: it pauses counting, or on a rising edge it restarts the cycle. Both outputs are registered. They show the channel state after the clock edge at which the inputs were sampled.

Top module: `pit_channel`

## Requirements
- R1: A loaded value of 0x0000 acts as an initial count N of 65536.
- R2: Mode code 0 (`mode_sel`=3'd0): `out_pin` is low from the load until the elapsed tick count d reaches N. It then stays high until the next load.
- R3: Mode code 1: `out_pin` is high while d < N and low once d >= N.
- R4: Mode code 2: `out_pin` is high only while d is a nonzero multiple of N. At every other time it is low.
- R5: Mode code 3: `out_pin` is high while (d mod N) < (N+1)/2 and low for the rest of each period of N ticks.
- R6: Mode codes 4 and 5: `out_pin` is high only while d equals N, with no later transition.
- R7: In mode codes 1, 2, 3 and 5, a rising edge on `gate` (gate high now, low in the previous cycle) sets d back to 0 in that cycle.
- R8: In mode codes 0 and 4, ticks that arrive while `gate` is low are ignored, so `count_value` and `out_pin` hold. A high gate resumes counting.
- R9: `count_value` is (N - d) mod 65536 in mode codes 0, 1, 4 and 5. It is N - (d mod N) in mode code 2 and N - (2d mod N) in mode code 3, each taken mod 65536.
- R10: After reset the channel is in mode code 3 with N = 65536 and d = 0, so `out_pin` is 1 and `count_value` is 0.
- R11: A load sets N and the mode, takes priority over a tick or a gate edge in the same cycle, and sets d to 0. The next cycle therefore shows `count_value` equal to the loaded value.
- R12: Mode codes 6 and 7 behave as mode codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable; one tick per cycle it is high |
| gate | input | 1 | Gate level; pauses or retriggers depending on mode |
| load | input | 1 | Load strobe for a new count and mode |
| load_value | input | CW | Initial count; 0 means 2^CW |
| mode_sel | input | 3 | Mode code sampled with `load` |
| out_pin | output | 1 | Channel output waveform |
| count_value | output | CW | Current count for readback |

## Verification
The channel keeps three views of its progress: a wrapping down counter, two modulo phases, and a saturating elapsed count. A fault in one view reaches the ports only in the modes that read that view. A corrupted phase shows on `count_value` in the very next cycle in mode codes 2 and 3. In those modes it shows on `out_pin` only when the next period boundary arrives. A wrong saturating count stays hidden until d reaches N, so the bench drives each mode past its terminal count and, for 2^16, all the way to the end. Gate-edge detection errors show up one cycle after the edge, as a count that fails to jump back to N.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [2:0] {
    PM_TC_INT    = 3'd0,
    PM_ONESHOT   = 3'd1,
    PM_RATE      = 3'd2,
    PM_SQUARE    = 3'd3,
    PM_SW_STROBE = 3'd4,
    PM_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic pit_mode_e decode_mode(input logic [2:0] sel);
    if (sel[2] && sel[1]) return pit_mode_e'({1'b0, sel[1:0]});
    return pit_mode_e'(sel);
  endfunction

  function automatic logic gate_restarts(input pit_mode_e m);
    return (m == PM_ONESHOT) || (m == PM_RATE) || (m == PM_SQUARE) || (m == PM_HW_STROBE);
  endfunction

  function automatic logic gate_pauses(input pit_mode_e m);
    return (m == PM_TC_INT) || (m == PM_SW_STROBE);
  endfunction

endpackage

// File: rtl/pit_modulo_phase.sv
// Tracks (STEP * d) mod limit; STEP may be 1 or 2.
module pit_modulo_phase #(
  parameter int CW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  input  logic [CW:0]   limit,
  output logic [CW:0]   ph_nxt
);
  localparam int SW = CW + 2;

  logic [CW:0]   ph_q;
  logic [SW-1:0] lim_w;
  logic [SW-1:0] sum;
  logic [SW-1:0] red1;
  logic [SW-1:0] red2;

  assign lim_w = {1'b0, limit};
  assign sum   = {1'b0, ph_q} + SW'(STEP);
  assign red1  = (sum >= lim_w) ? (sum - lim_w) : sum;

  generate
    if (STEP > 1) begin : g_second_wrap
      assign red2 = (red1 >= lim_w) ? (red1 - lim_w) : red1;
    end else begin : g_single_wrap
      assign red2 = red1;
    end
  endgenerate

  always_comb begin
    if (clear)    ph_nxt = '0;
    else if (adv) ph_nxt = red2[CW:0];
    else          ph_nxt = ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_nxt;
  end
endmodule

// File: rtl/pit_elapsed.sv
// Saturating elapsed-tick count and wrapping down counter for one-shot modes.
module pit_elapsed #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  input  logic [CW:0]   limit,
  output logic [CW:0]   dsat_nxt,
  output logic [CW-1:0] rem_nxt
);
  logic [CW:0]   dsat_q;
  logic [CW-1:0] rem_q;

  always_comb begin
    if (clear) begin
      dsat_nxt = '0;
      rem_nxt  = limit[CW-1:0];
    end else if (adv) begin
      dsat_nxt = (dsat_q > limit) ? dsat_q : dsat_q + 1'b1;
      rem_nxt  = rem_q - 1'b1;
    end else begin
      dsat_nxt = dsat_q;
      rem_nxt  = rem_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsat_q <= '0;
      rem_q  <= '0;
    end else begin
      dsat_q <= dsat_nxt;
      rem_q  <= rem_nxt;
    end
  end
endmodule

// File: rtl/pit_outsel.sv
// Output waveform and readback count, registered.
module pit_outsel
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  pit_mode_e     mode,
  input  logic [CW:0]   limit,
  input  logic [CW:0]   dsat,
  input  logic [CW-1:0] rem,
  input  logic [CW:0]   ph1,
  input  logic [CW:0]   ph2,
  output logic          out_q,
  output logic [CW-1:0] cnt_q
);
  logic [CW+1:0] half;
  logic          reached;
  logic          at_lim;
  logic          started;
  logic [CW:0]   diff;
  logic          out_c;
  logic [CW-1:0] cnt_c;

  assign half    = ({1'b0, limit} + (CW+2)'(1)) >> 1;
  assign reached = (dsat >= limit);
  assign at_lim  = (dsat == limit);
  assign started = (dsat != '0);

  always_comb begin
    diff = '0;
    case (mode)
      PM_TC_INT:  out_c = reached;
      PM_ONESHOT: out_c = !reached;
      PM_RATE:    out_c = (ph1 == '0) && started;
      PM_SQUARE:  out_c = ({1'b0, ph1} < half);
      default:    out_c = at_lim;
    endcase
    case (mode)
      PM_RATE: begin
        diff  = limit - ph1;
        cnt_c = diff[CW-1:0];
      end
      PM_SQUARE: begin
        diff  = limit - ph2;
        cnt_c = diff[CW-1:0];
      end
      default: cnt_c = rem;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      out_q <= out_c;
      cnt_q <= cnt_c;
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load,
  input  logic [CW-1:0] load_value,
  input  logic [2:0]    mode_sel,
  output logic          out_pin,
  output logic [CW-1:0] count_value
);
  localparam logic [CW:0] FULL_COUNT = {1'b1, {CW{1'b0}}};

  pit_mode_e     mode_q, mode_nxt;
  logic [CW:0]   limit_q, limit_nxt;
  logic          gate_q;
  logic          gate_rise;
  logic          restart;
  logic          advance;
  logic [CW:0]   ph1_nxt, ph2_nxt, dsat_nxt;
  logic [CW-1:0] rem_nxt;

  assign mode_nxt  = load ? decode_mode(mode_sel) : mode_q;
  assign limit_nxt = !load ? limit_q :
                     (load_value == '0) ? FULL_COUNT : {1'b0, load_value};
  assign gate_rise = gate && !gate_q;
  assign restart   = load || (gate_rise && gate_restarts(mode_q));
  assign advance   = tick_en && !restart && (!gate_pauses(mode_q) || gate);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PM_SQUARE;
      limit_q <= FULL_COUNT;
      gate_q  <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      limit_q <= limit_nxt;
      gate_q  <= gate;
    end
  end

  pit_modulo_phase #(.CW(CW), .STEP(1)) phase_single_i (
    .clk(clk), .rst(rst), .clear(restart), .adv(advance),
    .limit(limit_nxt), .ph_nxt(ph1_nxt)
  );

  pit_modulo_phase #(.CW(CW), .STEP(2)) phase_double_i (
    .clk(clk), .rst(rst), .clear(restart), .adv(advance),
    .limit(limit_nxt), .ph_nxt(ph2_nxt)
  );

  pit_elapsed #(.CW(CW)) elapsed_i (
    .clk(clk), .rst(rst), .clear(restart), .adv(advance),
    .limit(limit_nxt), .dsat_nxt(dsat_nxt), .rem_nxt(rem_nxt)
  );

  pit_outsel #(.CW(CW)) outsel_i (
    .clk(clk), .rst(rst), .mode(mode_nxt), .limit(limit_nxt),
    .dsat(dsat_nxt), .rem(rem_nxt), .ph1(ph1_nxt), .ph2(ph2_nxt),
    .out_q(out_pin), .cnt_q(count_value)
  );
endmodule

// File: rtl/pit_channel_checker.sv
module pit_channel_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic [CW-1:0] load_value,
  input logic          gate,
  input logic          gate_q,
  input logic [2:0]    mode_q,
  input logic [CW-1:0] limit_low,
  input logic          out_pin,
  input logic [CW-1:0] count_value
);
  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_pin && count_value == '0));

  assert_load_restart_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_value == $past(load_value)));

  assert_tc_stays_high_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0 && out_pin && !load) |=> out_pin);

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 3'd0 || mode_q == 3'd4) && !gate && !load)
      |=> ($stable(count_value) && $stable(out_pin)));

  assert_gate_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
    (gate && !gate_q && !load &&
     (mode_q == 3'd1 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd5))
      |=> (count_value == $past(limit_low)));
endmodule

bind pit_channel pit_channel_checker #(.CW(CW)) checker_i (
  .clk(clk), .rst(rst), .load(load), .load_value(load_value),
  .gate(gate), .gate_q(gate_q), .mode_q(mode_q),
  .limit_low(limit_q[CW-1:0]), .out_pin(out_pin), .count_value(count_value)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          gate = 1'b0;
  logic          load = 1'b0;
  logic [CW-1:0] load_value = '0;
  logic [2:0]    mode_sel = 3'd0;
  logic          out_pin;
  logic [CW-1:0] count_value;

  always #4 clk = ~clk;

  pit_channel #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate(gate), .load(load),
    .load_value(load_value), .mode_sel(mode_sel),
    .out_pin(out_pin), .count_value(count_value)
  );

  int    vectors = 0;
  int    errors  = 0;
  string tag     = "R10";
  bit    finished = 1'b0;

  // reference model state
  int m_mode  = 3;
  int m_n     = 65536;
  int m_d     = 0;
  int m_gprev = 0;

  function automatic int norm_mode(input int s);
    return (s >= 6) ? s - 4 : s;
  endfunction

  function automatic int exp_out();
    case (m_mode)
      0: return (m_d >= m_n) ? 1 : 0;
      1: return (m_d < m_n) ? 1 : 0;
      2: return ((m_d % m_n) == 0 && m_d != 0) ? 1 : 0;
      3: return ((m_d % m_n) < ((m_n + 1) / 2)) ? 1 : 0;
      default: return (m_d == m_n) ? 1 : 0;
    endcase
  endfunction

  function automatic int exp_cnt();
    case (m_mode)
      2: return (m_n - (m_d % m_n)) % 65536;
      3: return (m_n - ((2 * m_d) % m_n)) % 65536;
      default: return (((m_n - m_d) % 65536) + 65536) % 65536;
    endcase
  endfunction

  task automatic compare();
    int eo;
    int ec;
    eo = exp_out();
    ec = exp_cnt();
    vectors++;
    if (int'(out_pin) != eo || int'(count_value) != ec) begin
      errors++;
      $display("FAIL %s mode=%0d d=%0d: out=%0d cnt=%0d expected out=%0d cnt=%0d",
               tag, m_mode, m_d, out_pin, count_value, eo, ec);
    end
  endtask

  task automatic step();
    bit rise;
    @(posedge clk);
    if (rst) begin
      m_mode = 3; m_n = 65536; m_d = 0; m_gprev = 0;
    end else begin
      rise = gate && (m_gprev == 0);
      if (load) begin
        m_mode = norm_mode(int'(mode_sel));
        m_n    = (load_value == '0) ? 65536 : int'(load_value);
        m_d    = 0;
      end else if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
        m_d = 0;
      end else if (tick_en && (!(m_mode == 0 || m_mode == 4) || gate)) begin
        m_d++;
      end
      m_gprev = gate ? 1 : 0;
    end
    @(negedge clk);
    if (!rst) compare();
  endtask

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      tick_en = ((i % div) == (div - 1));
      step();
    end
    tick_en = 1'b0;
  endtask

  task automatic do_load(input int md, input int val);
    load = 1'b1; mode_sel = 3'(md); load_value = CW'(val); tick_en = 1'b1;
    step();
    load = 1'b0; tick_en = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R10: reset state, then default square wave counting down by two
    tag = "R10"; run(6, 1);
    // R2: interrupt on terminal count, plus R11 load overriding a tick
    gate = 1'b1;
    tag = "R2"; do_load(0, 5); run(12, 1);
    // R8: gate low pauses mode 0
    tag = "R8"; do_load(0, 8); run(3, 1); gate = 1'b0; run(6, 1); gate = 1'b1; run(10, 1);
    // R3 and R9: one-shot with wrap past zero
    tag = "R3"; do_load(1, 4); run(10, 1);
    tag = "R7"; gate = 1'b0; run(2, 1); gate = 1'b1; run(9, 1);
    // R4: rate generator, slow ticks, and N=1
    tag = "R4"; do_load(2, 3); run(20, 2); do_load(2, 1); run(5, 1);
    tag = "R7"; do_load(2, 5); run(7, 1); gate = 1'b0; run(1, 1); gate = 1'b1; run(8, 1);
    // R5 and R9: square wave, odd and even counts
    tag = "R5"; do_load(3, 5); run(20, 1); do_load(3, 6); run(20, 3);
    tag = "R7"; gate = 1'b0; run(1, 1); gate = 1'b1; run(8, 1);
    // R6: strobes, gate hold in mode 4, retrigger in mode 5
    tag = "R6"; do_load(4, 3); run(12, 1);
    tag = "R8"; do_load(4, 6); run(2, 1); gate = 1'b0; run(5, 1); gate = 1'b1; run(8, 1);
    tag = "R6"; do_load(5, 2); run(6, 1);
    tag = "R7"; gate = 1'b0; run(1, 1); gate = 1'b1; run(6, 1);
    // R12: alias codes
    tag = "R12"; do_load(6, 4); run(10, 1); do_load(7, 3); run(10, 1);
    // R11: reload mid-count into another mode
    tag = "R11"; do_load(2, 7); run(4, 1); do_load(0, 2); run(5, 1);
    // R1: zero load means 65536, strobe at the very end
    tag = "R1"; do_load(0, 0); run(3, 1);
    do_load(4, 0); run(65540, 1);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule